// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two unsigned base-3 numbers of N digits each, plus a one-bit carry-in. Every digit ("trit") travels on a pair of binary wires. A chain of ternary full-adder cells produces the sum, with each cell passing a carry of 0 or 1 to the next cell. The default width is ten trits, which covers about the same range as a sixteen-bit binary adder (3^10 = 59049).

A parameter selects how the result leaves the block. It can come straight from the cell chain, or it can pass through an output register that loads on every clock edge and that a synchronous active-high reset clears. An error flag shows when any operand digit carries the unused code. It follows the same path as the sum.

Top module: `ternary_adder`

## Requirements
- R1: Every sum digit equals (a + b + c) mod 3, where a and b are the operand digits at that position and c is the carry into that position. Trit codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = 2. For example, 1+2+0 gives 0 and passes a carry, and 2+2+1 gives 2 and passes a carry.
- R2: `carryOut` is 1 exactly when opA + opB + carryIn is 3^N or more. The sum output then holds the total minus 3^N.
- R3: The carry between two digit positions is never more than 1. When both operand digits at a position are 0, no carry leaves that position. A carry-in of 1 ripples through a run of 2-digits and turns each of them into 0.
- R4: Digit i sits at bits [2i+1:2i], so the least significant trit is at the low end. For example, decimal 5 is 4'b0110 (trits 1,2) and decimal 8 is 4'b1010 (trits 2,2).
- R5: `digitErr` is 1 when any digit of opA or opB has the code 2'b11, and 0 when every digit is legal. The sum is unspecified while the flag is set.
- R6: When all operand digits are legal, no sum digit ever shows the code 2'b11.
- R7: With REG_OUT=1, the outputs show the result of the inputs present at the previous rising clock edge. With REG_OUT=0, the outputs follow the inputs combinationally.
- R8: With REG_OUT=1, a clock edge with `rst` high sets every sum trit to 0, `carryOut` to 0 and `digitErr` to 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opA | input | 2*N | First operand, N two-bit trits |
| opB | input | 2*N | Second operand, N two-bit trits |
| carryIn | input | 1 | Carry into the lowest digit (0 or 1) |
| sumOut | output | 2*N | Sum, N two-bit trits |
| carryOut | output | 1 | Carry out of the top digit (overflow past 3^N − 1) |
| digitErr | output | 1 | Illegal operand digit detected |

## Verification
The bench builds two copies of the block. The first uses N=2 with no output register. It is small enough to drive every legal pair of operands with both carry-in values, so every cell-table row and every carry path between the two digits is covered. The second uses N=10 with the output register, which brings the one-cycle latency, the reset, and long carry ripples through runs of 2-digits into reach. It is driven with seeded random operands plus directed maximum, overflow and illegal-code vectors.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;
  localparam trit_t TRIT_BAD  = 2'b11;

  // strobes from control to datapath output stage
  typedef struct packed {
    logic clear;
    logic capture;
  } regStrobe_t;

endpackage

// File: rtl/tern_full_cell.sv
module tern_full_cell
  import tern_pkg::*;
(
  input  trit_t aDig,
  input  trit_t bDig,
  input  logic  cIn,
  output trit_t sDig,
  output logic  cOut,
  output logic  bad
);

  trit_t aVal;
  trit_t bVal;
  logic [2:0] total;
  logic [2:0] wrapped;

  always_comb begin
    bad     = (aDig == TRIT_BAD) || (bDig == TRIT_BAD);
    aVal    = (aDig == TRIT_BAD) ? TRIT_ZERO : aDig;
    bVal    = (bDig == TRIT_BAD) ? TRIT_ZERO : bDig;
    total   = {1'b0, aVal} + {1'b0, bVal} + {2'b00, cIn};
    wrapped = total - 3'd3;
    if (total >= 3'd3) begin
      sDig = wrapped[1:0];
      cOut = 1'b1;
    end else begin
      sDig = total[1:0];
      cOut = 1'b0;
    end
  end

  always_comb begin
    if (!$isunknown({aDig, bDig, cIn}) && !bad) begin
      // R6
      cell_sum_code_chk: assert (sDig != TRIT_BAD);
    end
  end

endmodule

// File: rtl/tern_add_ctrl.sv
module tern_add_ctrl
  import tern_pkg::*;
(
  input  logic       rst,
  output regStrobe_t strb
);

  always_comb begin
    strb.clear   = rst;
    strb.capture = !rst;
  end

endmodule

// File: rtl/tern_add_dp.sv
module tern_add_dp
  import tern_pkg::*;
#(
  parameter int N       = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  regStrobe_t       strb,
  input  logic [2*N-1:0]   opA,
  input  logic [2*N-1:0]   opB,
  input  logic             carryIn,
  output logic [2*N-1:0]   sumOut,
  output logic             carryOut,
  output logic             digitErr
);

  localparam int VecW = 2 * N;

  logic [N:0]      carryChain;
  logic [VecW-1:0] sumComb;
  logic [N-1:0]    errVec;
  logic            errComb;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < N; i++) begin : g_digit
    tern_full_cell u_cell (
      .aDig (opA[2*i +: 2]),
      .bDig (opB[2*i +: 2]),
      .cIn  (carryChain[i]),
      .sDig (sumComb[2*i +: 2]),
      .cOut (carryChain[i+1]),
      .bad  (errVec[i])
    );

    always_comb begin
      if (!$isunknown({opA[2*i +: 2], opB[2*i +: 2], carryChain[i+1]})) begin
        // R3
        carry_bound_chk: assert (!((opA[2*i +: 2] == TRIT_ZERO) &&
                                   (opB[2*i +: 2] == TRIT_ZERO) &&
                                   carryChain[i+1]));
      end
    end
  end

  assign errComb = |errVec;

  always_comb begin
    logic anyBad;
    anyBad = 1'b0;
    for (int k = 0; k < N; k++) begin
      anyBad = anyBad | (&opA[2*k +: 2]) | (&opB[2*k +: 2]);
    end
    if (!$isunknown({opA, opB}) && !anyBad) begin
      // R5
      err_legal_chk: assert (!errComb);
    end
  end

  if (REG_OUT) begin : g_reg
    logic [VecW-1:0] sumQ;
    logic            carryQ;
    logic            errQ;

    always_ff @(posedge clk) begin
      if (strb.clear) begin
        sumQ   <= '0;
        carryQ <= 1'b0;
        errQ   <= 1'b0;
      end else if (strb.capture) begin
        sumQ   <= sumComb;
        carryQ <= carryChain[N];
        errQ   <= errComb;
      end
    end

    assign sumOut   = sumQ;
    assign carryOut = carryQ;
    assign digitErr = errQ;

    // R8
    reset_clear_chk: assert property (@(posedge clk)
      strb.clear |=> (sumQ == '0 && !carryQ && !errQ));

    // R7
    reg_latency_chk: assert property (@(posedge clk) disable iff (strb.clear)
      strb.capture |=> (sumQ == $past(sumComb) && carryQ == $past(carryChain[N])
                        && errQ == $past(errComb)));
  end else begin : g_comb
    logic unusedStrobes;
    logic unusedClk;
    assign unusedStrobes = ^strb;
    assign unusedClk     = clk;
    assign sumOut   = sumComb;
    assign carryOut = carryChain[N];
    assign digitErr = errComb;
  end

endmodule

// File: rtl/ternary_adder.sv
module ternary_adder
  import tern_pkg::*;
#(
  parameter int N       = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] opA,
  input  logic [2*N-1:0] opB,
  input  logic           carryIn,
  output logic [2*N-1:0] sumOut,
  output logic           carryOut,
  output logic           digitErr
);

  regStrobe_t strb;

  tern_add_ctrl u_ctrl (
    .rst  (rst),
    .strb (strb)
  );

  tern_add_dp #(.N(N), .REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut),
    .digitErr (digitErr)
  );

endmodule

// File: tb/test_ternary_adder.sv
`timescale 1ns/1ps
module test_ternary_adder;

  localparam int NB = 10;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NB-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [2*NB-1:0] sumOut;
  logic carryOut, digitErr;

  logic [2*NS-1:0] sA = '0, sB = '0;
  logic sCin = 1'b0;
  logic [2*NS-1:0] sSum;
  logic sCout, sErr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ternary_adder #(.N(NB), .REG_OUT(1'b1)) i_ternary_adder (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut), .digitErr(digitErr));

  ternary_adder #(.N(NS), .REG_OUT(1'b0)) i_ternary_adder_small (
    .clk(clk), .rst(rst), .opA(sA), .opB(sB), .carryIn(sCin),
    .sumOut(sSum), .carryOut(sCout), .digitErr(sErr));

  function automatic int pow3(int n);
    int p = 1;
    for (int i = 0; i < n; i++) p = p * 3;
    return p;
  endfunction

  function automatic logic [2*NB-1:0] enc(int v, int n);
    logic [2*NB-1:0] r = '0;
    int x = v;
    for (int i = 0; i < n; i++) begin
      r[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic int dec(logic [2*NB-1:0] t, int n);
    int val = 0;
    int pw = 1;
    for (int i = 0; i < n; i++) begin
      val = val + int'(t[2*i +: 2]) * pw;
      pw = pw * 3;
    end
    return val;
  endfunction

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // big registered instance: drive at negedge, check at following negedge
  task automatic bigStep(int a, int b, bit c, string req);
    int tot, md;
    opA = enc(a, NB); opB = enc(b, NB); carryIn = c;
    @(negedge clk);
    md = pow3(NB);
    tot = a + b + int'(c);
    check({req, " sum"}, dec(sumOut, NB), tot % md);
    check({req, " carry"}, carryOut, (tot >= md) ? 1 : 0);
    check({req, " err"}, digitErr, 0);
  endtask

  task automatic smallStep(int a, int b, bit c, string req);
    int tot, md;
    logic [2*NB-1:0] ta, tb;
    ta = enc(a, NS); tb = enc(b, NS);
    sA = ta[2*NS-1:0]; sB = tb[2*NS-1:0]; sCin = c;
    #1;
    md = pow3(NS);
    tot = a + b + int'(c);
    check({req, " sum"}, dec({16'b0, sSum}, NS), tot % md);
    check({req, " carry"}, sCout, (tot >= md) ? 1 : 0);
    check({req, " err"}, sErr, 0);
    check("R6 code", ((sSum[1:0] == 2'b11) || (sSum[3:2] == 2'b11)) ? 1 : 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mx;
    void'($urandom(32'h1A2B3C4D));
    mx = pow3(NB) - 1;

    // R8: reset clears while inputs present and illegal
    opA = {2'b11, {(NB-1){2'b10}}}; opB = {NB{2'b10}}; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset sum", sumOut, 0);
    check("R8 reset carry", carryOut, 0);
    check("R8 reset err", digitErr, 0);
    rst = 1'b0;

    // R4: digit placement
    bigStep(5, 0, 1'b0, "R4 five");
    check("R4 five bits", sumOut[3:0], 4'b0110);
    bigStep(8, 0, 1'b0, "R4 eight");
    check("R4 eight bits", sumOut[3:0], 4'b1010);

    // R7: output holds old value until the next edge
    opA = enc(7, NB); opB = enc(1, NB); carryIn = 1'b0;
    #1;
    check("R7 before edge", dec(sumOut, NB), 8);
    @(negedge clk);
    check("R7 after edge", dec(sumOut, NB), 8);
    bigStep(100, 23, 1'b1, "R7 next");

    // R3: long ripple through all-2 digits
    bigStep(mx, 0, 1'b1, "R3 ripple");
    check("R3 ripple zeros", sumOut, 0);
    bigStep(mx, mx, 1'b1, "R3 max max");
    // R2: boundaries
    bigStep(mx, 0, 1'b0, "R2 max no carry");
    bigStep(mx - 4, 4, 1'b1, "R2 exact overflow");
    bigStep(0, 0, 1'b0, "R2 zero");

    // R5: illegal code at top digit, registered
    opA = {2'b11, {(NB-1){2'b00}}}; opB = '0; carryIn = 1'b0;
    @(negedge clk);
    check("R5 err reg top", digitErr, 1);
    opA = '0; opB = {{(NB-1){2'b00}}, 2'b11};
    @(negedge clk);
    check("R5 err reg low", digitErr, 1);
    bigStep(3, 3, 1'b0, "R5 legal clears");

    // R1: cell table rows on the small comb instance, digit 0 then carry into digit 1
    smallStep(1, 2, 1'b0, "R1 1+2+0");
    check("R1 1+2+0 digit", sSum[3:0], 4'b0100);
    smallStep(2, 2, 1'b0, "R1 2+2+0");
    check("R1 2+2+0 digit", sSum[3:0], 4'b0101);
    smallStep(2, 2, 1'b1, "R1 2+2+1");
    check("R1 2+2+1 digit", sSum[3:0], 4'b0110);
    smallStep(0, 2, 1'b1, "R1 0+2+1");
    check("R1 0+2+1 digit", sSum[3:0], 4'b0100);

    // R5 comb: illegal digit flags immediately
    sA = 4'b1100; sB = 4'b0000; sCin = 1'b0;
    #1;
    check("R5 err comb", sErr, 1);

    // R1 R2 exhaustive on N=2
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++)
        for (int c = 0; c < 2; c++)
          smallStep(a, b, c[0], "R1 R2 exhaustive");

    // R2 R7 random on N=10
    @(negedge clk);
    for (int k = 0; k < 1500; k++) begin
      int a, b;
      a = int'($urandom % (mx + 1));
      b = int'($urandom % (mx + 1));
      bigStep(a, b, 1'($urandom), "R2 random");
    end

    // R8 mid-run reset
    opA = enc(mx, NB); opB = enc(mx, NB); carryIn = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R8 midrun sum", sumOut, 0);
    check("R8 midrun carry", carryOut, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 release", dec(sumOut, NB), (2 * mx + 1) % (mx + 1));

    finish_run();
  end

endmodule